// File: doc/BRIEF.md
# Byte-Level I2C Master with Completion-Flag Handshake

This block is a single-master I2C controller that works one bus operation at a time. Software picks an operation through a control register: a START (first or repeated), sending one byte, receiving one byte, or a STOP. It starts the operation by writing the control register with the done-flag bit set. The sequencer drives SCL and SDA as open-drain enables, captures the acknowledge bit, writes an 8-bit status code and raises the done flag again. While the flag is up the controller holds SCL low, so the bus waits for software. A STOP ends with both lines released, and no flag is raised after it.

Software reaches four byte-wide registers. Address 0 is control. Its bits are: 7 done flag, 6 ACK-to-send, 5 START, 4 STOP, 3 write collision (read only), 2 enable, 1 receive. Address 1 is data, address 2 is status and address 3 is the prescaler. When a control write carries a one in bit 7, it selects the operation by priority: START, then STOP, then receive, and otherwise send. Enable must already be set by an earlier write before an operation can be launched.

Top module: `i2c_flag_master`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xF8 and both line enables are 0 (released).
- R2: A launch write with bit 5 set puts a START on the bus, meaning SDA falls while SCL is high. The controller then raises the flag and status reads 0x08.
- R3: While the done flag is set, SCL is driven low (scl_oe_o = 1).
- R4: A control write with bit 7 = 1 clears the flag and starts the selected operation. A control write with bit 7 = 0 leaves the flag set and starts nothing.
- R5: A send operation shifts the data register MSB first over 9 SCL pulses, and the 9th pulse samples ACK. The first byte after a START sets status to 0x18 on ACK or 0x20 on NACK. Later bytes set 0x28 on ACK or 0x30 on NACK.
- R6: A receive operation loads the received byte into the data register. On the 9th pulse the master drives SDA low only if bit 6 was set in the launch write. Status is then 0x50 if it acknowledged, or 0x58 if it did not.
- R7: A STOP raises SDA while SCL is high and then releases both lines. Status returns to 0xF8 and the done flag stays clear.
- R8: Inside a byte, SDA changes only while SCL is low. The only SDA edges while SCL is high are the requested START and STOP conditions.
- R9: A data-register write while an operation runs is ignored and sets control bit 3. The next accepted data write clears bit 3.
- R10: Writing control with bit 2 = 0 clears the flag, returns status to 0xF8 and releases both lines within two cycles.
- R11: With prescaler value P, each quarter bit lasts P+1 cycles. The flag reads set 4(P+1)+1 cycles after a START launch edge, and 36(P+1)+1 cycles after a byte launch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 control, 1 data, 2 status, 3 prescaler) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| sda_oe_o | output | 1 | 1 pulls SDA low |

## Verification
Register reads are combinational, and a write takes effect at the edge that samples it. The bench therefore reads back one half-cycle after that edge. Bus operations finish a fixed number of edges after the launch edge: 4(P+1)+1 for START and 36(P+1)+1 for a byte. The bench counts falling edges from the launch edge until the flag reads set, and compares that count exactly. The STOP and disable cases are checked after a settle window long enough to cover the full condition. The STOP check also confirms that the flag never rose during that window.

// File: rtl/i2c_fm_pkg.sv
package i2c_fm_pkg;
  typedef enum logic [1:0] {CMD_TX, CMD_RX, CMD_START, CMD_STOP} cmd_e;
  typedef enum logic [2:0] {ST_IDLE, ST_HOLD, ST_START, ST_BYTE, ST_STOP} seq_state_e;

  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NACK = 8'h20;
  localparam logic [7:0] SC_DW_ACK  = 8'h28;
  localparam logic [7:0] SC_DW_NACK = 8'h30;
  localparam logic [7:0] SC_RX_ACK  = 8'h50;
  localparam logic [7:0] SC_RX_NACK = 8'h58;
  localparam logic [7:0] SC_IDLE    = 8'hF8;

  localparam int CB_FLAG = 7;
  localparam int CB_ACK  = 6;
  localparam int CB_STA  = 5;
  localparam int CB_STO  = 4;
  localparam int CB_WCOL = 3;
  localparam int CB_EN   = 2;
  localparam int CB_RX   = 1;

  localparam logic [1:0] RA_CTRL  = 2'd0;
  localparam logic [1:0] RA_DATA  = 2'd1;
  localparam logic [1:0] RA_STAT  = 2'd2;
  localparam logic [1:0] RA_PRESC = 2'd3;
endpackage

// File: rtl/i2c_fm_tick.sv
module i2c_fm_tick #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [PW-1:0] presc_i,
  output logic          tick_o
);
  logic [PW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2c_fm_seq.sv
module i2c_fm_seq
  import i2c_fm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       go_i,
  input  cmd_e       cmd_i,
  input  logic       ack_en_i,
  input  logic [7:0] tx_byte_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rx_load_o,
  output logic [7:0] status_o,
  output logic [7:0] rx_byte_o,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  localparam int BITS = 9;
  localparam int BW   = $clog2(BITS + 1);

  seq_state_e    state_q;
  logic [1:0]    qph_q;
  logic [BW-1:0] bitn_q;
  logic [7:0]    sh_q, status_q;
  logic          is_rx_q, ack_q, from_hold_q, addr_ph_q, samp_q, hold_sda_q;
  logic          done_q, stop_done_q;
  logic          last_bit;

  assign last_bit  = (bitn_q == BW'(BITS - 1));
  assign busy_o    = (state_q == ST_START) || (state_q == ST_BYTE) || (state_q == ST_STOP);
  assign done_o    = done_q;
  assign rx_load_o = done_q && is_rx_q;
  assign status_o  = status_q;
  assign rx_byte_o = sh_q;

  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    case (state_q)
      ST_HOLD:  begin scl_oe_o = 1'b1; sda_oe_o = hold_sda_q; end
      ST_START: begin scl_oe_o = (qph_q == 2'd0) && from_hold_q; sda_oe_o = qph_q[1]; end
      ST_BYTE:  begin
        scl_oe_o = !qph_q[1];
        sda_oe_o = last_bit ? (is_rx_q && ack_q) : (!is_rx_q && !sh_q[7]);
      end
      ST_STOP:  begin scl_oe_o = (qph_q == 2'd0); sda_oe_o = (qph_q != 2'd3); end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE; qph_q <= '0; bitn_q <= '0; sh_q <= '0; status_q <= SC_IDLE;
      is_rx_q <= 1'b0; ack_q <= 1'b0; from_hold_q <= 1'b0; addr_ph_q <= 1'b0;
      samp_q <= 1'b1; hold_sda_q <= 1'b0; done_q <= 1'b0; stop_done_q <= 1'b0;
    end else if (!en_i) begin
      state_q <= ST_IDLE; qph_q <= '0; bitn_q <= '0; status_q <= SC_IDLE;
      addr_ph_q <= 1'b0; hold_sda_q <= 1'b0; done_q <= 1'b0; stop_done_q <= 1'b0;
    end else begin
      done_q      <= 1'b0;
      stop_done_q <= 1'b0;
      if (go_i && !busy_o) begin
        case (cmd_i)
          CMD_START: state_q <= ST_START;
          CMD_STOP:  state_q <= ST_STOP;
          default:   state_q <= ST_BYTE;
        endcase
        qph_q       <= '0;
        bitn_q      <= '0;
        from_hold_q <= (state_q == ST_HOLD);
        is_rx_q     <= (cmd_i == CMD_RX);
        ack_q       <= ack_en_i;
        sh_q        <= tx_byte_i;
      end else if (tick_i && busy_o) begin
        qph_q <= qph_q + 2'd1;
        if (qph_q == 2'd2) samp_q <= sda_i;  // mid-high sample
        if (qph_q == 2'd3) begin
          case (state_q)
            ST_START: begin
              state_q <= ST_HOLD; done_q <= 1'b1; status_q <= SC_START;
              addr_ph_q <= 1'b1; hold_sda_q <= 1'b1;
            end
            ST_STOP: begin
              state_q <= ST_IDLE; stop_done_q <= 1'b1; status_q <= SC_IDLE;
              addr_ph_q <= 1'b0;
            end
            default: begin
              if (last_bit) begin
                state_q    <= ST_HOLD;
                done_q     <= 1'b1;
                hold_sda_q <= is_rx_q && ack_q;
                if (is_rx_q)        status_q <= ack_q  ? SC_RX_ACK  : SC_RX_NACK;
                else if (addr_ph_q) status_q <= samp_q ? SC_AW_NACK : SC_AW_ACK;
                else                status_q <= samp_q ? SC_DW_NACK : SC_DW_ACK;
                if (!is_rx_q) addr_ph_q <= 1'b0;
              end else begin
                sh_q   <= {sh_q[6:0], samp_q};
                bitn_q <= bitn_q + 1'b1;
              end
            end
          endcase
        end
      end
    end
  end

  // R8
  sda_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BYTE && $past(state_q) == ST_BYTE && !scl_oe_o && !$past(scl_oe_o))
      |-> $stable(sda_oe_o));

  // R7
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_done_q |-> (!scl_oe_o && !sda_oe_o && status_q == SC_IDLE && !done_q));
endmodule

// File: rtl/i2c_fm_regs.sv
module i2c_fm_regs
  import i2c_fm_pkg::*;
#(
  parameter int            PW        = 8,
  parameter logic [PW-1:0] PRESC_RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic          rx_load_i,
  input  logic [7:0]    rx_byte_i,
  input  logic [7:0]    status_i,
  output logic [7:0]    rdata_o,
  output logic          go_o,
  output cmd_e          cmd_o,
  output logic          ack_en_o,
  output logic          en_o,
  output logic [7:0]    tx_byte_o,
  output logic [PW-1:0] presc_o,
  output logic          flag_o
);
  logic          flag_q, ack_q, sta_q, sto_q, wcol_q, en_q, rx_q;
  logic [7:0]    data_q, presc_rd;
  logic [PW-1:0] presc_q;
  logic          ctrl_wr, data_wr;

  assign ctrl_wr = we_i && (addr_i == RA_CTRL);
  assign data_wr = we_i && (addr_i == RA_DATA);
  assign go_o    = ctrl_wr && wdata_i[CB_FLAG] && wdata_i[CB_EN] && en_q && !busy_i;
  assign cmd_o   = wdata_i[CB_STA] ? CMD_START :
                   wdata_i[CB_STO] ? CMD_STOP  :
                   wdata_i[CB_RX]  ? CMD_RX    : CMD_TX;
  assign ack_en_o  = wdata_i[CB_ACK];
  assign en_o      = en_q;
  assign tx_byte_o = data_q;
  assign presc_o   = presc_q;
  assign flag_o    = flag_q;

  always_comb begin
    presc_rd = '0;
    presc_rd[PW-1:0] = presc_q;
    case (addr_i)
      RA_CTRL:  rdata_o = {flag_q, ack_q, sta_q, sto_q, wcol_q, en_q, rx_q, 1'b0};
      RA_DATA:  rdata_o = data_q;
      RA_STAT:  rdata_o = status_i;
      default:  rdata_o = presc_rd;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0; ack_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      en_q <= 1'b0; rx_q <= 1'b0; wcol_q <= 1'b0; data_q <= '0; presc_q <= PRESC_RST;
    end else begin
      if (ctrl_wr) begin
        ack_q <= wdata_i[CB_ACK]; sta_q <= wdata_i[CB_STA]; sto_q <= wdata_i[CB_STO];
        en_q  <= wdata_i[CB_EN];  rx_q  <= wdata_i[CB_RX];
      end
      // write-one clears; zero leaves the flag alone
      if (ctrl_wr && (!wdata_i[CB_EN] || wdata_i[CB_FLAG])) flag_q <= 1'b0;
      else if (done_i)                                      flag_q <= 1'b1;

      if (data_wr) begin
        if (busy_i) wcol_q <= 1'b1;
        else begin data_q <= wdata_i; wcol_q <= 1'b0; end
      end else if (rx_load_i) begin
        data_q <= rx_byte_i;
      end

      if (we_i && addr_i == RA_PRESC) presc_q <= wdata_i[PW-1:0];
    end
  end

  // R4
  flag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(ctrl_wr && (wdata_i[CB_FLAG] || !wdata_i[CB_EN]))) |=> flag_q);

  // R9
  wcol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy_i) |=> ($stable(data_q) && wcol_q));
endmodule

// File: rtl/i2c_flag_master.sv
module i2c_flag_master
  import i2c_fm_pkg::*;
#(
  parameter int            PRESC_W   = 8,
  parameter logic [PRESC_W-1:0] PRESC_RST = PRESC_W'(1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [1:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic               busy, done, rx_load, go, ack_en, en, flag, tick;
  cmd_e               cmd;
  logic [7:0]         status, rx_byte, tx_byte;
  logic [PRESC_W-1:0] presc;

  i2c_fm_regs #(.PW(PRESC_W), .PRESC_RST(PRESC_RST)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .busy_i(busy), .done_i(done), .rx_load_i(rx_load), .rx_byte_i(rx_byte),
    .status_i(status), .rdata_o(reg_rdata_o), .go_o(go), .cmd_o(cmd),
    .ack_en_o(ack_en), .en_o(en), .tx_byte_o(tx_byte), .presc_o(presc), .flag_o(flag)
  );

  i2c_fm_tick #(.PW(PRESC_W)) u_tick (
    .clk_i, .rst_ni, .run_i(busy), .presc_i(presc), .tick_o(tick)
  );

  i2c_fm_seq u_seq (
    .clk_i, .rst_ni, .en_i(en), .go_i(go), .cmd_i(cmd), .ack_en_i(ack_en),
    .tx_byte_i(tx_byte), .tick_i(tick), .sda_i, .busy_o(busy), .done_o(done),
    .rx_load_o(rx_load), .status_o(status), .rx_byte_o(rx_byte),
    .scl_oe_o, .sda_oe_o
  );

  // R3
  flag_scl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag |-> scl_oe_o);

  // R10
  en_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (!scl_oe_o && !sda_oe_o));
endmodule

// File: tb/i2c_flag_master_test.sv
module i2c_flag_master_test;
  typedef struct packed {
    logic [1:0] op;     // 0 send, 1 receive, 2 start
    logic [7:0] presc;
    logic       ack;    // slave ACK for send, master ACK for receive
    logic [7:0] dat;
    logic [7:0] st;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 8'd1, 1'b0, 8'h00, 8'h08},
    '{2'd0, 8'd1, 1'b1, 8'hA4, 8'h18},
    '{2'd0, 8'd1, 1'b1, 8'h5B, 8'h28},
    '{2'd0, 8'd1, 1'b0, 8'hC3, 8'h30},
    '{2'd1, 8'd1, 1'b1, 8'h96, 8'h50},
    '{2'd1, 8'd1, 1'b0, 8'h3C, 8'h58},
    '{2'd2, 8'd0, 1'b0, 8'h00, 8'h08},
    '{2'd0, 8'd0, 1'b0, 8'hA5, 8'h20},
    '{2'd0, 8'd2, 1'b1, 8'h01, 8'h28}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       scl_oe, sda_oe, sda_line, slv_pull;
  logic       slv_rx = 1'b0, slv_ack = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  logic [3:0] fall_cnt;
  logic [8:0] cap9;
  logic       prev_scl, prev_sda;
  int         starts, stops;
  int         nchk = 0, nfail = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  assign slv_pull = slv_rx ? (fall_cnt < 4'd8 && !slv_byte[3'd7 - fall_cnt[2:0]])
                           : (fall_cnt == 4'd8 && slv_ack);
  assign sda_line = !(sda_oe || slv_pull);

  i2c_flag_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  // bus monitor and slave bit counter
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= 4'd9; cap9 <= '0; prev_scl <= 1'b1; prev_sda <= 1'b1;
      starts <= 0; stops <= 0;
    end else begin
      if (we && addr == 2'd0 && wdata[7]) begin
        fall_cnt <= 4'd0; cap9 <= '0;
      end else begin
        if (prev_scl && scl_oe && fall_cnt != 4'd15) fall_cnt <= fall_cnt + 4'd1;
        if (!prev_scl && !scl_oe) cap9 <= {cap9[7:0], sda_line};
      end
      if (prev_scl && !scl_oe && prev_sda && !sda_line) starts <= starts + 1;
      if (prev_scl && !scl_oe && !prev_sda && sda_line) stops <= stops + 1;
      prev_scl <= !scl_oe;
      prev_sda <= sda_line;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_flag(output int cyc);
    logic [7:0] c;
    cyc = 0;
    rd(2'd0, c);
    while (!c[7] && cyc < 5000) begin
      @(negedge clk); cyc++; rd(2'd0, c);
    end
  endtask

  initial begin
    logic [7:0] d;
    int cyc, exp_cyc, st_before;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, d); check("R1 ctrl", d, 8'h00);
    rd(2'd2, d); check("R1 status", d, 8'hF8);
    check("R1 lines", {scl_oe, sda_oe}, 2'b00);
    wr(2'd0, 8'h04);
    check("R1 enable idle lines", {scl_oe, sda_oe}, 2'b00);

    for (int i = 0; i < NV; i++) begin
      wr(2'd3, VECS[i].presc);
      if (VECS[i].op == 2'd0) wr(2'd1, VECS[i].dat);
      slv_rx = (VECS[i].op == 2'd1); slv_ack = (VECS[i].op == 2'd0) && VECS[i].ack;
      slv_byte = VECS[i].dat;
      st_before = starts;
      wr(2'd0, {1'b1, (VECS[i].op == 2'd1) && VECS[i].ack, VECS[i].op == 2'd2,
                2'b00, 1'b1, VECS[i].op == 2'd1, 1'b0});
      wait_flag(cyc);
      exp_cyc = (VECS[i].op == 2'd2 ? 4 : 36) * (int'(VECS[i].presc) + 1) + 1;
      check("R11 flag delay", cyc, exp_cyc);
      rd(2'd2, d); check("R5 R6 R2 status", d, VECS[i].st);
      check("R3 scl held", scl_oe, 1'b1);
      case (VECS[i].op)
        2'd2: check("R2 start seen", starts, st_before + 1);
        2'd0: begin
          check("R5 byte on wire", cap9[8:1], VECS[i].dat);
          check("R5 ack bit", cap9[0], !VECS[i].ack);
        end
        default: begin
          rd(2'd1, d); check("R6 rx data", d, VECS[i].dat);
          check("R6 master ack", cap9[0], !VECS[i].ack);
        end
      endcase
    end

    // R4: writing zero to the flag bit
    wr(2'd0, 8'h04);
    repeat (30) @(negedge clk);
    rd(2'd0, d); check("R4 flag kept", d[7], 1'b1);
    check("R3 scl still held", scl_oe, 1'b1);
    rd(2'd2, d); check("R4 no op started", d, 8'h28);

    // R9: collision during a send
    wr(2'd1, 8'h3A);
    rd(2'd0, d); check("R9 no wcol when flag set", d[3], 1'b0);
    slv_rx = 1'b0; slv_ack = 1'b1;
    wr(2'd0, 8'h84);
    wr(2'd1, 8'h77);
    rd(2'd0, d); check("R9 wcol set", d[3], 1'b1);
    wait_flag(cyc);
    rd(2'd1, d); check("R9 data kept", d, 8'h3A);
    check("R9 sent byte kept", cap9[8:1], 8'h3A);
    wr(2'd1, 8'h55);
    rd(2'd0, d); check("R9 wcol cleared", d[3], 1'b0);

    // R7: stop
    slv_ack = 1'b0;
    st_before = stops;
    wr(2'd0, 8'h94);
    seen = 1'b0;
    for (int k = 0; k < 200; k++) begin
      rd(2'd0, d); if (d[7]) seen = 1'b1;
      @(negedge clk);
    end
    check("R7 no flag after stop", seen, 1'b0);
    rd(2'd2, d); check("R7 status idle", d, 8'hF8);
    check("R7 stop seen", stops, st_before + 1);
    check("R7 lines released", {scl_oe, sda_oe}, 2'b00);

    // R10: disable in the middle of a transfer
    wr(2'd3, 8'd1);
    wr(2'd0, 8'hA4);
    wait_flag(cyc);
    check("R10 start before disable", cyc, 9);
    wr(2'd0, 8'h00);
    repeat (2) @(negedge clk);
    check("R10 lines released", {scl_oe, sda_oe}, 2'b00);
    rd(2'd0, d); check("R10 ctrl cleared", d, 8'h00);
    rd(2'd2, d); check("R10 status idle", d, 8'hF8);

    // R8: no stray SDA edges while SCL high
    check("R8 start count", starts, 3);
    check("R8 stop count", stops, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule